// File: doc/BRIEF.md
# Direct Transfer Data and Address Register

This block is the holding register between a processor and its external direct I/O lines for direct read and direct write instructions. It has a data field and an address field. The data field captures a word from the external input lines when the operation reads from a device. It captures a word from the internal sum bus when the operation writes to a device. The address field always captures the low bits of a general register and fills its upper bits with zeros.

The stored data word is gated onto exactly one bus. During a read it drives the sum bus, so that the word can reach the processor. During a write it drives the external output lines, so that it can reach the device. When no direction is selected, both buses are held at zero. Selecting both directions at once is illegal: the block flags it and blocks every load. Each field has its own clear control, and a clear beats a load.

Top module: `dio_xfer_reg`

## Requirements
- R1: After the asynchronous active-low reset, the data field and the address field are zero, and `sum_out_o`, `dio_out_o`, `out_vld_o` and `dir_err_o` are zero while no direction is selected.
- R2: On a rising edge with `data_ld_i`=1, `rd_dir_i`=1, `wr_dir_i`=0 and `data_clr_i`=0, the data field takes the value of `dio_in_i`.
- R3: On a rising edge with `data_ld_i`=1, `wr_dir_i`=1, `rd_dir_i`=0 and `data_clr_i`=0, the data field takes the value of `sum_in_i`.
- R4: On a rising edge with `addr_ld_i`=1, `addr_clr_i`=0 and no direction conflict, the address field takes `gr_i` in its bits ADDR_SRC_W-1..0 (bit i of `gr_i` goes to bit i). Bits ADDR_W-1..ADDR_SRC_W become zero.
- R5: While only `rd_dir_i` is high, `sum_out_o` equals the data field and `dio_out_o` is zero. While only `wr_dir_i` is high, `dio_out_o` equals the data field and `sum_out_o` is zero. `addr_o` always shows the address field.
- R6: On a rising edge with `data_clr_i`=1, the data field becomes zero whatever the load and direction inputs are. On a rising edge with `addr_clr_i`=1, the address field becomes zero in the same way.
- R7: `out_vld_o` is 1 exactly when one direction input is high. While neither direction input is high, both data outputs are zero.
- R8: While `rd_dir_i` and `wr_dir_i` are both high, `dir_err_o` is 1 and both data outputs are zero. A clock edge in that state loads neither field, although a clear still acts.
- R9: A data load with neither direction selected leaves the data field unchanged. An edge with no load and no clear leaves both fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_dir_i | input | 1 | Direct read operation in progress |
| wr_dir_i | input | 1 | Direct write operation in progress |
| data_ld_i | input | 1 | Load enable, data field |
| addr_ld_i | input | 1 | Load enable, address field |
| data_clr_i | input | 1 | Clear, data field |
| addr_clr_i | input | 1 | Clear, address field |
| dio_in_i | input | DATA_W | External direct I/O input lines |
| sum_in_i | input | DATA_W | Internal sum bus input |
| gr_i | input | ADDR_SRC_W | Low bits of the general register |
| sum_out_o | output | DATA_W | Data gated onto the sum bus (read) |
| dio_out_o | output | DATA_W | Data gated onto the external lines (write) |
| addr_o | output | ADDR_W | Address field |
| out_vld_o | output | 1 | Exactly one direction is active |
| dir_err_o | output | 1 | Both directions requested |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=6 and ADDR_SRC_W=4. The six control inputs have 64 combinations, and at this size the sweep can apply every one of them, each with four computed data and address patterns. Clear priority, the blocked loads under a direction conflict and idle-direction loads are therefore all exercised, in every order in which they can meet. With ADDR_SRC_W below ADDR_W, the zero-filled upper address bits can be seen at the ports.

// File: rtl/dio_pkg.sv
`timescale 1ns/1ps
package dio_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_RD   = 2'b01,
    DIR_WR   = 2'b10,
    DIR_BAD  = 2'b11
  } dir_e;
endpackage

// File: rtl/dio_dir_decode.sv
`timescale 1ns/1ps
module dio_dir_decode
  import dio_pkg::*;
(
  input  logic rd_i,
  input  logic wr_i,
  output dir_e dir_o,
  output logic vld_o,
  output logic err_o
);
  always_comb begin
    unique case ({wr_i, rd_i})
      2'b01:   dir_o = DIR_RD;
      2'b10:   dir_o = DIR_WR;
      2'b11:   dir_o = DIR_BAD;
      default: dir_o = DIR_IDLE;
    endcase
  end

  assign vld_o = (dir_o == DIR_RD) || (dir_o == DIR_WR);
  assign err_o = (dir_o == DIR_BAD);
endmodule

// File: rtl/dio_data_field.sv
`timescale 1ns/1ps
module dio_data_field
  import dio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  dir_e              dir_i,
  input  logic [DATA_W-1:0] dio_in_i,
  input  logic [DATA_W-1:0] sum_in_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q, data_d;

  // clear first, then a load whose source depends on direction
  always_comb begin
    data_d = data_q;
    if (clr_i) begin
      data_d = '0;
    end else if (ld_i) begin
      unique case (dir_i)
        DIR_RD:  data_d = dio_in_i;
        DIR_WR:  data_d = sum_in_i;
        default: data_d = data_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/dio_addr_field.sv
`timescale 1ns/1ps
module dio_addr_field #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_SRC_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  ld_i,
  input  logic                  block_i,
  input  logic [ADDR_SRC_W-1:0] gr_i,
  output logic [ADDR_W-1:0]     addr_o
);
  logic [ADDR_W-1:0] src_ext;
  logic [ADDR_W-1:0] addr_q;

  // bits above the source width are tied to zero
  for (genvar i = 0; i < ADDR_W; i++) begin : g_ext
    if (i < ADDR_SRC_W) begin : g_src
      assign src_ext[i] = gr_i[i];
    end else begin : g_zero
      assign src_ext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             addr_q <= '0;
    else if (clr_i)          addr_q <= '0;
    else if (ld_i && !block_i) addr_q <= src_ext;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dio_out_gate.sv
`timescale 1ns/1ps
module dio_out_gate
  import dio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  dir_e              dir_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_out_o,
  output logic [DATA_W-1:0] dio_out_o
);
  always_comb begin
    sum_out_o = '0;
    dio_out_o = '0;
    unique case (dir_i)
      DIR_RD:  sum_out_o = data_i;
      DIR_WR:  dio_out_o = data_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/dio_xfer_reg.sv
`timescale 1ns/1ps
module dio_xfer_reg
  import dio_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_SRC_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_dir_i,
  input  logic                  wr_dir_i,
  input  logic                  data_ld_i,
  input  logic                  addr_ld_i,
  input  logic                  data_clr_i,
  input  logic                  addr_clr_i,
  input  logic [DATA_W-1:0]     dio_in_i,
  input  logic [DATA_W-1:0]     sum_in_i,
  input  logic [ADDR_SRC_W-1:0] gr_i,
  output logic [DATA_W-1:0]     sum_out_o,
  output logic [DATA_W-1:0]     dio_out_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  out_vld_o,
  output logic                  dir_err_o
);
  dir_e              dir;
  logic [DATA_W-1:0] data_q;

  dio_dir_decode u_dir (
    .rd_i  (rd_dir_i),
    .wr_i  (wr_dir_i),
    .dir_o (dir),
    .vld_o (out_vld_o),
    .err_o (dir_err_o)
  );

  dio_data_field #(.DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (data_clr_i),
    .ld_i     (data_ld_i),
    .dir_i    (dir),
    .dio_in_i (dio_in_i),
    .sum_in_i (sum_in_i),
    .data_o   (data_q)
  );

  dio_addr_field #(.ADDR_W(ADDR_W), .ADDR_SRC_W(ADDR_SRC_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (addr_clr_i),
    .ld_i    (addr_ld_i),
    .block_i (dir_err_o),
    .gr_i    (gr_i),
    .addr_o  (addr_o)
  );

  dio_out_gate #(.DATA_W(DATA_W)) u_gate (
    .dir_i     (dir),
    .data_i    (data_q),
    .sum_out_o (sum_out_o),
    .dio_out_o (dio_out_o)
  );
endmodule

// File: rtl/dio_xfer_reg_chk.sv
`timescale 1ns/1ps
module dio_xfer_reg_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_SRC_W = 14
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_dir_i,
  input logic                  wr_dir_i,
  input logic                  data_ld_i,
  input logic                  addr_ld_i,
  input logic                  data_clr_i,
  input logic                  addr_clr_i,
  input logic [DATA_W-1:0]     dio_in_i,
  input logic [DATA_W-1:0]     sum_in_i,
  input logic [ADDR_SRC_W-1:0] gr_i,
  input logic [DATA_W-1:0]     sum_out_o,
  input logic [DATA_W-1:0]     dio_out_o,
  input logic [ADDR_W-1:0]     addr_o,
  input logic                  out_vld_o,
  input logic                  dir_err_o,
  input logic [DATA_W-1:0]     data_q
);
  p_rd_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ld_i && rd_dir_i && !wr_dir_i && !data_clr_i) |=> data_q == $past(dio_in_i));

  p_wr_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ld_i && wr_dir_i && !rd_dir_i && !data_clr_i) |=> data_q == $past(sum_in_i));

  p_addr_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ld_i && !addr_clr_i && !(rd_dir_i && wr_dir_i))
      |=> addr_o == ADDR_W'($past(gr_i)));

  p_rd_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dir_i && !wr_dir_i) |-> (sum_out_o == data_q && dio_out_o == '0));

  p_wr_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dir_i && !rd_dir_i) |-> (dio_out_o == data_q && sum_out_o == '0));

  p_data_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_clr_i |=> data_q == '0);

  p_addr_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_clr_i |=> addr_o == '0);

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_dir_i && !wr_dir_i) |-> (!out_vld_o && sum_out_o == '0 && dio_out_o == '0));

  p_conflict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dir_i && wr_dir_i && !data_clr_i && !addr_clr_i)
      |=> (data_q == $past(data_q) && addr_o == $past(addr_o)));

  p_conflict_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dir_i && wr_dir_i) |-> (dir_err_o && !out_vld_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_dir_i && !wr_dir_i && !data_clr_i) |=> data_q == $past(data_q));
endmodule

bind dio_xfer_reg dio_xfer_reg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_SRC_W(ADDR_SRC_W)
) u_chk (.*);

// File: tb/sim_dio_xfer_reg.sv
`timescale 1ns/1ps
module sim_dio_xfer_reg;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 0, wr = 0, dld = 0, ald = 0, dclr = 0, aclr = 0;
  logic [DW-1:0] dio_in = '0, sum_in = '0;
  logic [SW-1:0] gr = '0;
  logic [DW-1:0] sum_out, dio_out;
  logic [AW-1:0] addr;
  logic vld, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dio_xfer_reg #(.DATA_W(DW), .ADDR_W(AW), .ADDR_SRC_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_dir_i(rd), .wr_dir_i(wr),
    .data_ld_i(dld), .addr_ld_i(ald), .data_clr_i(dclr), .addr_clr_i(aclr),
    .dio_in_i(dio_in), .sum_in_i(sum_in), .gr_i(gr),
    .sum_out_o(sum_out), .dio_out_o(dio_out), .addr_o(addr),
    .out_vld_o(vld), .dir_err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench model, from the requirements
  logic [DW-1:0] exp_d = '0;
  logic [AW-1:0] exp_a = '0;
  string d_tag = "R1";
  string a_tag = "R1";

  task automatic check_outputs();
    logic one_dir;
    one_dir = rd ^ wr;
    chk(rd && !wr ? {"R5 sum_out, data via ", d_tag} : "R7 sum_out idle/R8",
        int'(sum_out), (rd && !wr) ? int'(exp_d) : 0);
    chk(wr && !rd ? {"R5 dio_out, data via ", d_tag} : "R7 dio_out idle/R8",
        int'(dio_out), (wr && !rd) ? int'(exp_d) : 0);
    chk("R7 out_vld", int'(vld), int'(one_dir));
    chk("R8 dir_err", int'(err), int'(rd && wr));
    chk({"R5 addr_o via ", a_tag}, int'(addr), int'(exp_a));
  endtask

  task automatic model_edge();
    logic conf;
    conf = rd && wr;
    if (dclr) begin exp_d = '0; d_tag = "R6"; end
    else if (dld && conf) d_tag = "R8";
    else if (dld && rd) begin exp_d = dio_in; d_tag = "R2"; end
    else if (dld && wr) begin exp_d = sum_in; d_tag = "R3"; end
    else d_tag = "R9";
    if (aclr) begin exp_a = '0; a_tag = "R6"; end
    else if (ald && conf) a_tag = "R8";
    else if (ald) begin exp_a = AW'(gr); a_tag = "R4"; end
    else a_tag = "R9";
  endtask

  initial begin
    #3;
    // R1: reset state
    chk("R1 sum_out", int'(sum_out), 0);
    chk("R1 dio_out", int'(dio_out), 0);
    chk("R1 addr_o", int'(addr), 0);
    chk("R1 out_vld", int'(vld), 0);
    chk("R1 dir_err", int'(err), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        {aclr, dclr, ald, dld, wr, rd} = 6'(c ^ (p * 21));
        dio_in = DW'(c * 37 + p * 91 + 5);
        sum_in = DW'(~(c * 53 + p * 17));
        gr     = SW'(c * 7 + p * 3 + 1);
        #1;
        check_outputs();
        @(posedge clk);
        model_edge();
      end
    end
    // observe final state through both directions
    @(negedge clk);
    {aclr, dclr, ald, dld, wr, rd} = 6'b000001;
    #1 check_outputs();
    wr = 1'b1; rd = 1'b0;
    #1 check_outputs();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule